// File: doc/BRIEF.md
# VLAN Table Indirect Access Engine

This block holds a 4096-entry VLAN table. The table is indexed by a 12-bit VLAN ID. Each entry stores three fields: an 8-bit member port mask, an 8-bit untag port mask and a 3-bit filtering ID. Software never addresses the table directly. It loads the VLAN ID and the entry fields into three staging words. It then writes a command word to a control register, which starts a table write or a table read. A table read places its result in three separate result words. The result words keep their value until the next read completes.

A command runs for a fixed number of cycles, set by `EXEC_CYCLES`. While it runs, the control register reads back as busy. The block latches the VLAN ID and the entry fields when it accepts the command, so the staging words may be rewritten while the command is still running. Every entry reads as zero after reset.

Top module: `vlan_tbl_access`

## Requirements
- R1: After reset, every staging word, every result word and the control register read as 0x0000.
- R2: The staging words keep only their defined fields and read back masked. Word 0 (0x0185) holds the VLAN ID in bits 11:0. Word 1 (0x0186) holds the member mask in bits 7:0 and the untag mask in bits 15:8. Word 2 (0x0187) holds the filtering ID in bits 2:0.
- R3: Writing 0x0F01 to the control register (0x0180) stores the staged member mask, untag mask and filtering ID into the entry selected by the staged VLAN ID.
- R4: Writing 0x0E01 to the control register reads the entry selected by staging word 0. The result words hold the same fields at the same positions as the staging words: 0x018C holds the VLAN ID, 0x018D holds {untag, member} and 0x018E holds the filtering ID.
- R5: An accepted command makes the control register read 0x0001 for exactly `EXEC_CYCLES` sampled cycles, starting on the cycle after the write. After that it reads 0x0000.
- R6: A control register write whose value is neither 0x0E01 nor 0x0F01 is ignored. Busy does not rise, the result words do not change and the table does not change.
- R7: A command written while busy is ignored. Busy ends on the schedule of the first command, and the ignored command has no effect.
- R8: An entry that has not been written since the last reset reads back with member, untag and filtering ID all zero.
- R9: The result words change only when a read command completes. A write command leaves them unchanged.
- R10: The operands are taken from the staging words when the command is accepted. Rewriting the staging words while busy does not change the operation in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register write strobe, qualified by we_i |
| we_i | input | 1 | Write enable for the register access |
| addr_i | input | 16 | Register address, for both write and read |
| wdata_i | input | 16 | Register write data |
| rdata_o | output | 16 | Read data for addr_i, combinational |

## Verification
The assertions assume that the host waits for busy to clear before it relies on the result words. They also assume that register writes are single-cycle strobes on `req_i`. The stimulus polls the control register until it reads zero before it reads any result word. It raises `req_i` for exactly one cycle per write, and it issues commands during busy only in the directed cases that test that commands are ignored while busy.

// File: rtl/vt_pkg.sv
package vt_pkg;
  localparam logic [15:0] ADDR_CTRL = 16'h0180;
  localparam logic [15:0] ADDR_WB0  = 16'h0185;
  localparam logic [15:0] ADDR_WB1  = 16'h0186;
  localparam logic [15:0] ADDR_WB2  = 16'h0187;
  localparam logic [15:0] ADDR_RB0  = 16'h018C;
  localparam logic [15:0] ADDR_RB1  = 16'h018D;
  localparam logic [15:0] ADDR_RB2  = 16'h018E;
  localparam logic [15:0] CMD_READ  = 16'h0E01;
  localparam logic [15:0] CMD_WRITE = 16'h0F01;

  typedef enum logic {OP_RD = 1'b0, OP_WR = 1'b1} op_e;
endpackage

// File: rtl/vt_store.sv
module vt_store #(
  parameter int VID_W = 12,
  parameter int ENT_W = 19
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [VID_W-1:0] addr_i,
  input  logic [ENT_W-1:0] wdata_i,
  output logic [ENT_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << VID_W;

  logic [ENT_W-1:0] mem_q [DEPTH];
  logic [DEPTH-1:0] vld_q;

  // valid bits give all-zero entries after reset without clearing the array
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= '0;
    else if (we_i) vld_q[addr_i] <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end

  assign rdata_o = vld_q[addr_i] ? mem_q[addr_i] : '0;

  assert_write_marks_valid_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> vld_q[$past(addr_i)]);
endmodule

// File: rtl/vt_seq.sv
module vt_seq
  import vt_pkg::*;
#(
  parameter int EXEC_CYCLES = 3,
  parameter int VID_W       = 12,
  parameter int ENT_W       = 19
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  op_e              op_i,
  input  logic [VID_W-1:0] vid_i,
  input  logic [ENT_W-1:0] ent_i,
  output logic             busy_o,
  output logic             tbl_we_o,
  output logic             rd_done_o,
  output logic [VID_W-1:0] vid_o,
  output logic [ENT_W-1:0] ent_o
);
  localparam int CNT_W = $clog2(EXEC_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  op_e              op_q;
  logic [VID_W-1:0] vid_q;
  logic [ENT_W-1:0] ent_q;
  logic             done;

  assign done = busy_q && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      op_q   <= OP_RD;
      vid_q  <= '0;
      ent_q  <= '0;
    end else if (start_i && !busy_q) begin
      cnt_q  <= CNT_W'(EXEC_CYCLES - 1);
      busy_q <= 1'b1;
      op_q   <= op_i;
      vid_q  <= vid_i;
      ent_q  <= ent_i;
    end else if (done) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy_o    = busy_q;
  assign tbl_we_o  = done && (op_q == OP_WR);
  assign rd_done_o = done && (op_q == OP_RD);
  assign vid_o     = vid_q;
  assign ent_o     = ent_q;

  assert_start_sets_busy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o);
  assert_start_only_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_o);
  assert_done_clears_busy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && cnt_q == '0) |=> !busy_o);
endmodule

// File: rtl/vt_regs.sv
module vt_regs
  import vt_pkg::*;
#(
  parameter int VID_W  = 12,
  parameter int MASK_W = 8,
  parameter int FID_W  = 3,
  localparam int ENT_W = FID_W + 2 * MASK_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [15:0]      addr_i,
  input  logic [15:0]      wdata_i,
  output logic [15:0]      rdata_o,
  input  logic             busy_i,
  input  logic             rd_done_i,
  input  logic [VID_W-1:0] rd_vid_i,
  input  logic [ENT_W-1:0] rd_ent_i,
  output logic             start_o,
  output op_e              op_o,
  output logic [VID_W-1:0] vid_o,
  output logic [ENT_W-1:0] ent_o
);
  logic [VID_W-1:0]  wb_vid_q, rb_vid_q;
  logic [MASK_W-1:0] wb_mem_q, wb_unt_q, rb_mem_q, rb_unt_q;
  logic [FID_W-1:0]  wb_fid_q, rb_fid_q;
  logic              wr;

  assign wr = req_i && we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wb_vid_q <= '0;
      wb_mem_q <= '0;
      wb_unt_q <= '0;
      wb_fid_q <= '0;
    end else if (wr) begin
      unique case (addr_i)
        ADDR_WB0: wb_vid_q <= wdata_i[VID_W-1:0];
        ADDR_WB1: begin
          wb_mem_q <= wdata_i[MASK_W-1:0];
          wb_unt_q <= wdata_i[MASK_W +: MASK_W];
        end
        ADDR_WB2: wb_fid_q <= wdata_i[FID_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rb_vid_q <= '0;
      rb_mem_q <= '0;
      rb_unt_q <= '0;
      rb_fid_q <= '0;
    end else if (rd_done_i) begin
      rb_vid_q <= rd_vid_i;
      {rb_fid_q, rb_unt_q, rb_mem_q} <= rd_ent_i;
    end
  end

  assign start_o = wr && (addr_i == ADDR_CTRL) && !busy_i &&
                   ((wdata_i == CMD_READ) || (wdata_i == CMD_WRITE));
  assign op_o    = (wdata_i == CMD_WRITE) ? OP_WR : OP_RD;
  assign vid_o   = wb_vid_q;
  assign ent_o   = {wb_fid_q, wb_unt_q, wb_mem_q};

  always_comb begin
    unique case (addr_i)
      ADDR_CTRL: rdata_o = {15'd0, busy_i};
      ADDR_WB0:  rdata_o = 16'(wb_vid_q);
      ADDR_WB1:  rdata_o = 16'({wb_unt_q, wb_mem_q});
      ADDR_WB2:  rdata_o = 16'(wb_fid_q);
      ADDR_RB0:  rdata_o = 16'(rb_vid_q);
      ADDR_RB1:  rdata_o = 16'({rb_unt_q, rb_mem_q});
      ADDR_RB2:  rdata_o = 16'(rb_fid_q);
      default:   rdata_o = 16'd0;
    endcase
  end

  assert_rdbuf_stable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_done_i |=> $stable({rb_vid_q, rb_unt_q, rb_mem_q, rb_fid_q}));
endmodule

// File: rtl/vlan_tbl_access.sv
module vlan_tbl_access
  import vt_pkg::*;
#(
  parameter int EXEC_CYCLES = 3,
  parameter int VID_W       = 12,
  parameter int MASK_W      = 8,
  parameter int FID_W       = 3
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        we_i,
  input  logic [15:0] addr_i,
  input  logic [15:0] wdata_i,
  output logic [15:0] rdata_o
);
  localparam int ENT_W = FID_W + 2 * MASK_W;

  logic             start, busy, tbl_we, rd_done;
  op_e              op;
  logic [VID_W-1:0] wb_vid, cap_vid;
  logic [ENT_W-1:0] wb_ent, cap_ent, tbl_rd;

  vt_regs #(.VID_W(VID_W), .MASK_W(MASK_W), .FID_W(FID_W)) u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o,
    .busy_i(busy), .rd_done_i(rd_done), .rd_vid_i(cap_vid), .rd_ent_i(tbl_rd),
    .start_o(start), .op_o(op), .vid_o(wb_vid), .ent_o(wb_ent)
  );

  vt_seq #(.EXEC_CYCLES(EXEC_CYCLES), .VID_W(VID_W), .ENT_W(ENT_W)) u_seq (
    .clk_i, .rst_ni, .start_i(start), .op_i(op), .vid_i(wb_vid), .ent_i(wb_ent),
    .busy_o(busy), .tbl_we_o(tbl_we), .rd_done_o(rd_done),
    .vid_o(cap_vid), .ent_o(cap_ent)
  );

  vt_store #(.VID_W(VID_W), .ENT_W(ENT_W)) u_store (
    .clk_i, .rst_ni, .we_i(tbl_we), .addr_i(cap_vid), .wdata_i(cap_ent),
    .rdata_o(tbl_rd)
  );
endmodule

// File: tb/sim_vlan_tbl_access.sv
module sim_vlan_tbl_access;
  localparam int CLK_PERIOD = 10;
  localparam int EXEC = 3;
  localparam logic [15:0] A_CTRL = 16'h0180, A_W0 = 16'h0185, A_W1 = 16'h0186,
                          A_W2 = 16'h0187, A_R0 = 16'h018C, A_R1 = 16'h018D,
                          A_R2 = 16'h018E;
  localparam logic [15:0] C_RD = 16'h0E01, C_WR = 16'h0F01;
  // {vid, untag, member, fid}
  localparam logic [30:0] VEC [6] = '{
    {12'd1,    8'hA5, 8'h3C, 3'd7},
    {12'd4095, 8'h01, 8'hFF, 3'd0},
    {12'd0,    8'hFF, 8'h00, 3'd3},
    {12'd2048, 8'h12, 8'h34, 3'd5},
    {12'd77,   8'h80, 8'h7F, 3'd1},
    {12'd3000, 8'h00, 8'h3F, 3'd6}
  };

  logic clk = 0, rst_n = 0, req = 0, we = 0;
  logic [15:0] addr = 0, wdata = 0, rdata;
  int n_chk = 0, n_fail = 0;

  vlan_tbl_access #(.EXEC_CYCLES(EXEC)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(string r, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [15:0] d);
    req = 1; we = 1; addr = a; wdata = d;
    @(posedge clk); #1;
    req = 0; we = 0;
  endtask

  task automatic rd(logic [15:0] a, output logic [15:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic wait_idle();
    logic [15:0] v;
    for (int i = 0; i < 20; i++) begin
      rd(A_CTRL, v);
      if (v == 16'd0) return;
      @(posedge clk); #1;
    end
    chk("R5 idle", v, 16'd0);
  endtask

  task automatic tbl_wr(logic [11:0] vid, logic [7:0] unt, logic [7:0] mem, logic [2:0] fid);
    wr(A_W0, {4'd0, vid}); wr(A_W1, {unt, mem}); wr(A_W2, {13'd0, fid});
    wr(A_CTRL, C_WR); wait_idle();
  endtask

  task automatic tbl_rd_chk(string r, logic [11:0] vid, logic [7:0] unt, logic [7:0] mem, logic [2:0] fid);
    logic [15:0] v;
    wr(A_W0, {4'd0, vid}); wr(A_CTRL, C_RD); wait_idle();
    rd(A_R0, v); chk(r, v, {4'd0, vid});
    rd(A_R1, v); chk(r, v, {unt, mem});
    rd(A_R2, v); chk(r, v, {13'd0, fid});
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_fail++;
    $display("FAIL watchdog act=running exp=done");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int cnt;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    foreach (VEC[i]) begin end
    rd(A_CTRL, v); chk("R1 ctrl", v, 0);
    rd(A_W0, v); chk("R1 w0", v, 0);
    rd(A_W1, v); chk("R1 w1", v, 0);
    rd(A_R1, v); chk("R1 r1", v, 0);
    rst_n = 1;
    @(posedge clk); #1;

    // R2 masking
    wr(A_W0, 16'hF123); rd(A_W0, v); chk("R2 w0 mask", v, 16'h0123);
    wr(A_W1, 16'hBEEF); rd(A_W1, v); chk("R2 w1", v, 16'hBEEF);
    wr(A_W2, 16'hFFFD); rd(A_W2, v); chk("R2 w2 mask", v, 16'h0005);

    // R8 unwritten entry
    tbl_rd_chk("R8 unwritten", 12'd4094, 0, 0, 0);

    // R3/R4 vector table
    for (int i = 0; i < 6; i++)
      tbl_wr(VEC[i][30:19], VEC[i][18:11], VEC[i][10:3], VEC[i][2:0]);
    for (int i = 0; i < 6; i++)
      tbl_rd_chk("R3 R4 vec", VEC[i][30:19], VEC[i][18:11], VEC[i][10:3], VEC[i][2:0]);

    // R5 busy window length
    wr(A_W0, 16'd5); wr(A_CTRL, C_RD);
    cnt = 0;
    for (int i = 0; i < 10; i++) begin
      rd(A_CTRL, v);
      if (v == 16'h0001) cnt++;
      @(posedge clk); #1;
    end
    chk("R5 busy cycles", 16'(cnt), 16'(EXEC));

    // R9 write command leaves result words alone (last read was vid 5, zero entry)
    tbl_wr(12'd5, 8'h11, 8'h22, 3'd4);
    rd(A_R0, v); chk("R9 r0", v, 16'd5);
    rd(A_R1, v); chk("R9 r1", v, 16'd0);

    // R6 unknown commands
    wr(A_W0, 16'd1); wr(A_CTRL, 16'h0E00);
    rd(A_CTRL, v); chk("R6 no busy", v, 0);
    wr(A_CTRL, 16'h1F01);
    rd(A_CTRL, v); chk("R6 no busy 2", v, 0);
    rd(A_R0, v); chk("R6 r0 kept", v, 16'd5);

    // R7 command while busy ignored
    wr(A_W0, 16'd9); wr(A_W1, 16'h5566); wr(A_CTRL, C_WR);
    wr(A_W0, 16'd1); wr(A_CTRL, C_RD);
    @(posedge clk); #1;
    rd(A_CTRL, v); chk("R7 first schedule", v, 0);
    rd(A_R0, v); chk("R7 no read", v, 16'd5);

    // R10 snapshot of operands
    wr(A_W0, 16'd200); wr(A_W1, 16'hAAAA); wr(A_W2, 16'd2); wr(A_CTRL, C_WR);
    wr(A_W0, 16'd201); wr(A_W1, 16'h1111);
    wait_idle();
    tbl_rd_chk("R10 snap", 12'd200, 8'hAA, 8'hAA, 3'd2);
    tbl_rd_chk("R10 other", 12'd201, 0, 0, 0);

    // R8 after second reset
    rst_n = 0; #1; rst_n = 1;
    @(posedge clk); #1;
    rd(A_R1, v); chk("R1 rb after reset", v, 0);
    tbl_rd_chk("R8 after reset", 12'd1, 0, 0, 0);

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule